// File: doc/BRIEF.md
# Control-Driven 32-bit Integer ALU

This block is the integer execute unit of a small in-order RISC pipeline. It never looks at an opcode. The decode stage gives it a set of control fields, and the ALU combines two operands under those fields. Operand 2 first passes through a preconditioner that can pass it, invert it, move its low half into the upper half, or force it to zero. A single adder then covers addition, subtraction, load-upper-immediate and the set-less-than comparison. A logic unit and a barrel shifter sit beside the adder.

Three comparison flags are produced for every operation, whatever the result select. The branch logic reads them: operand 1 below zero, the operands equal, and operand 1 less than operand 2. The outputs go through a register by default (`REG_OUT = 1`), which gives one cycle of latency. With `REG_OUT = 0` the block is purely combinational.

Top module: `alu32_ctl`

## Requirements
- R1: The preconditioned operand 2 is chosen by `op2_sel_i`. 00 passes `b_i`, 01 gives `~b_i`, 10 gives `b_i << 16`, and 11 gives zero. The adder adds this value, operand 1 and a carry-in equal to `op2_sel_i[0]`.
- R2: With `op2_sel_i` = 01 and arithmetic enabled, the result is `a_i - b_i` modulo 2^32. Any carry or overflow out of bit 31 is dropped, and no trap or flag is raised for it.
- R3: The logic unit uses `logic_sel_i` as follows: 00 gives AND, 01 gives OR, 10 gives XOR, and 11 passes `b_i`. When `logic_inv_i` = 1 the logic result is inverted, so NOR is 01 with the invert bit set.
- R4: The shifter shifts `b_i` by `shamt_i` bits. `shift_sel_i` = 10 gives a logical right shift and 11 an arithmetic right shift. Both 00 and 01 give a logical left shift.
- R5: In set-less-than mode the result is 1 in bit 0 when `lt_o` is true and 0 otherwise, and bits 31..1 are always zero. `cmp_unsigned_i` = 1 makes the comparison unsigned; otherwise it is signed.
- R6: The flags are produced on every operation. `ltz_o` is bit 31 of `a_i`, `eq_o` means `a_i == b_i`, and `lt_o` means `a_i < b_i` (signed unless `cmp_unsigned_i` = 1).
- R7: Result priority: `slt_en_i` first, then `arith_en_i`, then `logic_en_i`, then `shift_en_i`. When none of them is set, the result is the adder output.
- R8: `a_zero_i` = 1 replaces operand 1 with zero at the adder input only. With `op2_sel_i` = 10 this gives load-upper-immediate. The flags still use `a_i`.
- R9: With `REG_OUT` = 1 the result and flags appear one clock after their inputs. An active-low asynchronous reset clears all of them to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_i | input | 32 | Operand 1 |
| b_i | input | 32 | Operand 2 |
| shamt_i | input | 5 | Shift distance |
| op2_sel_i | input | 2 | Operand-2 preconditioning select |
| logic_sel_i | input | 2 | Logic function select |
| logic_inv_i | input | 1 | Invert the logic result |
| shift_sel_i | input | 2 | Shift kind select |
| arith_en_i | input | 1 | Select the adder result |
| logic_en_i | input | 1 | Select the logic result |
| shift_en_i | input | 1 | Select the shifter result |
| slt_en_i | input | 1 | Select the set-less-than result |
| cmp_unsigned_i | input | 1 | Unsigned comparison |
| a_zero_i | input | 1 | Force operand 1 to zero at the adder |
| result_o | output | 32 | Result |
| ltz_o | output | 1 | Operand 1 is negative |
| eq_o | output | 1 | Operands equal |
| lt_o | output | 1 | Operand 1 less than operand 2 |

## Verification
The checker assumes that the control fields and operands stay steady from one clock edge to the next. It copies them through a register of its own so that they line up with the registered outputs, and it ignores the first cycle after reset, when that register holds no real input yet. The bench drives every input on the falling edge and samples half a period later, after the rising edge, so every vector meets this assumption. Its operands come from the five edge values 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF and from a deterministic pseudo-random generator.

// File: rtl/alu32_pkg.sv
package alu32_pkg;
  typedef enum logic [1:0] {
    OP2_PASS = 2'b00,
    OP2_INV  = 2'b01,
    OP2_HI   = 2'b10,
    OP2_ZERO = 2'b11
  } op2_sel_e;

  typedef enum logic [1:0] {
    LG_AND  = 2'b00,
    LG_OR   = 2'b01,
    LG_XOR  = 2'b10,
    LG_PASS = 2'b11
  } logic_sel_e;

  typedef enum logic [1:0] {
    SH_LL  = 2'b00,
    SH_LL2 = 2'b01,
    SH_RL  = 2'b10,
    SH_RA  = 2'b11
  } shift_sel_e;
endpackage

// File: rtl/alu32_precond.sv
module alu32_precond
  import alu32_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] b_i,
  input  logic [1:0]   sel_i,
  output logic [W-1:0] b_o
);
  localparam int HALF = W / 2;

  always_comb begin
    unique case (op2_sel_e'(sel_i))
      OP2_PASS: b_o = b_i;
      OP2_INV:  b_o = ~b_i;
      OP2_HI:   b_o = {b_i[W-HALF-1:0], {HALF{1'b0}}};
      default:  b_o = '0;
    endcase
  end
endmodule

// File: rtl/alu32_logic.sv
module alu32_logic
  import alu32_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   sel_i,
  input  logic         inv_i,
  output logic [W-1:0] y_o
);
  logic [W-1:0] raw;

  always_comb begin
    unique case (logic_sel_e'(sel_i))
      LG_AND:  raw = a_i & b_i;
      LG_OR:   raw = a_i | b_i;
      LG_XOR:  raw = a_i ^ b_i;
      default: raw = b_i;
    endcase
  end

  assign y_o = inv_i ? ~raw : raw;
endmodule

// File: rtl/alu32_shifter.sv
module alu32_shifter #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   d_i,
  input  logic [SHW-1:0] amt_i,
  input  logic [1:0]     sel_i,
  output logic [W-1:0]   y_o
);
  logic           go_right;
  logic           fill;
  logic [W-1:0]   stg [SHW+1];

  // sel_i[1] picks direction, sel_i[0] picks sign fill on right shifts
  assign go_right = sel_i[1];
  assign fill     = sel_i[1] & sel_i[0] & d_i[W-1];
  assign stg[0]   = d_i;

  for (genvar i = 0; i < SHW; i++) begin : g_stage
    localparam int D = 1 << i;
    logic [W-1:0] moved;
    assign moved = go_right ? {{D{fill}}, stg[i][W-1:D]}
                            : {stg[i][W-D-1:0], {D{1'b0}}};
    assign stg[i+1] = amt_i[i] ? moved : stg[i];
  end

  assign y_o = stg[SHW];
endmodule

// File: rtl/alu32_cmp.sv
module alu32_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         uns_i,
  output logic         ltz_o,
  output logic         eq_o,
  output logic         lt_o
);
  logic lt_s, lt_u;

  assign lt_s  = $signed(a_i) < $signed(b_i);
  assign lt_u  = a_i < b_i;
  assign ltz_o = a_i[W-1];
  assign eq_o  = ~|(a_i ^ b_i);
  assign lt_o  = uns_i ? lt_u : lt_s;
endmodule

// File: rtl/alu32_ctl.sv
module alu32_ctl #(
  parameter int W       = 32,
  parameter int SHW     = $clog2(W),
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [SHW-1:0] shamt_i,
  input  logic [1:0]     op2_sel_i,
  input  logic [1:0]     logic_sel_i,
  input  logic           logic_inv_i,
  input  logic [1:0]     shift_sel_i,
  input  logic           arith_en_i,
  input  logic           logic_en_i,
  input  logic           shift_en_i,
  input  logic           slt_en_i,
  input  logic           cmp_unsigned_i,
  input  logic           a_zero_i,
  output logic [W-1:0]   result_o,
  output logic           ltz_o,
  output logic           eq_o,
  output logic           lt_o
);
  logic [W-1:0] b_pre, op1, sum, lg_y, sh_y, res_d;
  logic         ltz_d, eq_d, lt_d;

  alu32_precond #(.W(W)) u_pre (
    .b_i(b_i), .sel_i(op2_sel_i), .b_o(b_pre)
  );

  // carry-in follows the invert choice -> two's-complement subtract
  assign op1 = a_zero_i ? '0 : a_i;
  assign sum = op1 + b_pre + {{(W-1){1'b0}}, op2_sel_i[0]};

  alu32_logic #(.W(W)) u_lg (
    .a_i(a_i), .b_i(b_i), .sel_i(logic_sel_i), .inv_i(logic_inv_i), .y_o(lg_y)
  );

  alu32_shifter #(.W(W), .SHW(SHW)) u_sh (
    .d_i(b_i), .amt_i(shamt_i), .sel_i(shift_sel_i), .y_o(sh_y)
  );

  alu32_cmp #(.W(W)) u_cmp (
    .a_i(a_i), .b_i(b_i), .uns_i(cmp_unsigned_i),
    .ltz_o(ltz_d), .eq_o(eq_d), .lt_o(lt_d)
  );

  always_comb begin
    if (slt_en_i)        res_d = {{(W-1){1'b0}}, lt_d};
    else if (arith_en_i) res_d = sum;
    else if (logic_en_i) res_d = lg_y;
    else if (shift_en_i) res_d = sh_y;
    else                 res_d = sum;
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        result_o <= '0;
        ltz_o    <= 1'b0;
        eq_o     <= 1'b0;
        lt_o     <= 1'b0;
      end else begin
        result_o <= res_d;
        ltz_o    <= ltz_d;
        eq_o     <= eq_d;
        lt_o     <= lt_d;
      end
    end
  end else begin : g_comb
    assign result_o = res_d;
    assign ltz_o    = ltz_d;
    assign eq_o     = eq_d;
    assign lt_o     = lt_d;
  end
endmodule

// File: rtl/alu32_ctl_chk.sv
module alu32_ctl_chk #(
  parameter int W       = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [1:0]   op2_sel_i,
  input logic         arith_en_i,
  input logic         slt_en_i,
  input logic         cmp_unsigned_i,
  input logic         a_zero_i,
  input logic [W-1:0] result_o,
  input logic         eq_o,
  input logic         lt_o
);
  logic [W-1:0] s_a, s_b;
  logic [1:0]   s_o2;
  logic         s_ae, s_slt, s_un, s_az, vld;

  if (REG_OUT) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s_a <= '0; s_b <= '0; s_o2 <= '0;
        s_ae <= 1'b0; s_slt <= 1'b0; s_un <= 1'b0; s_az <= 1'b0; vld <= 1'b0;
      end else begin
        s_a <= a_i; s_b <= b_i; s_o2 <= op2_sel_i;
        s_ae <= arith_en_i; s_slt <= slt_en_i; s_un <= cmp_unsigned_i;
        s_az <= a_zero_i; vld <= 1'b1;
      end
    end
  end else begin : g_now
    assign s_a = a_i;  assign s_b = b_i;  assign s_o2 = op2_sel_i;
    assign s_ae = arith_en_i; assign s_slt = slt_en_i;
    assign s_un = cmp_unsigned_i; assign s_az = a_zero_i; assign vld = 1'b1;
  end

  AST_SLT_UPPER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld && s_slt) |-> (result_o[W-1:1] == '0)); // R5

  AST_EQ_EXCLUDES_LT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld && eq_o) |-> !lt_o); // R6

  AST_SIGNED_NEG_LT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld && !s_un && s_a[W-1] && !s_b[W-1]) |-> lt_o); // R6

  AST_SUB_SELF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld && !s_slt && s_ae && !s_az && s_o2 == 2'b01 && s_a == s_b)
      |-> (result_o == '0)); // R2

  AST_UPPER_IMM_LOW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld && !s_slt && s_ae && s_az && s_o2 == 2'b10)
      |-> (result_o[W/2-1:0] == '0)); // R8
endmodule

bind alu32_ctl alu32_ctl_chk #(.W(W), .REG_OUT(REG_OUT)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i),
  .op2_sel_i(op2_sel_i), .arith_en_i(arith_en_i), .slt_en_i(slt_en_i),
  .cmp_unsigned_i(cmp_unsigned_i), .a_zero_i(a_zero_i),
  .result_o(result_o), .eq_o(eq_o), .lt_o(lt_o)
);

// File: tb/alu32_ctl_tb_top.sv
`timescale 1ns/1ps
module alu32_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [4:0]  sh = '0;
  logic [1:0]  o2 = '0, ls = '0, ss = '0;
  logic        li = 0, ae = 0, le = 0, se = 0, te = 0, un = 0, az = 0;
  logic [31:0] r_res, c_res;
  logic        r_ltz, r_eq, r_lt, c_ltz, c_eq, c_lt;
  int          n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  alu32_ctl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .shamt_i(sh),
    .op2_sel_i(o2), .logic_sel_i(ls), .logic_inv_i(li), .shift_sel_i(ss),
    .arith_en_i(ae), .logic_en_i(le), .shift_en_i(se), .slt_en_i(te),
    .cmp_unsigned_i(un), .a_zero_i(az),
    .result_o(r_res), .ltz_o(r_ltz), .eq_o(r_eq), .lt_o(r_lt)
  );

  alu32_ctl #(.REG_OUT(1'b0)) dut_c_i (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .shamt_i(sh),
    .op2_sel_i(o2), .logic_sel_i(ls), .logic_inv_i(li), .shift_sel_i(ss),
    .arith_en_i(ae), .logic_en_i(le), .shift_en_i(se), .slt_en_i(te),
    .cmp_unsigned_i(un), .a_zero_i(az),
    .result_o(c_res), .ltz_o(c_ltz), .eq_o(c_eq), .lt_o(c_lt)
  );

  function automatic logic ref_lt(input logic [31:0] x, y, input logic u);
    return u ? (x < y) : ($signed(x) < $signed(y));
  endfunction

  function automatic logic [31:0] ref_res();
    logic [31:0] p, s, g, q;
    case (o2)
      2'b00: p = b;
      2'b01: p = ~b;
      2'b10: p = {b[15:0], 16'h0};
      default: p = 32'h0;
    endcase
    s = (az ? 32'h0 : a) + p + {31'h0, o2[0]};
    case (ls)
      2'b00: g = a & b;
      2'b01: g = a | b;
      2'b10: g = a ^ b;
      default: g = b;
    endcase
    if (li) g = ~g;
    case (ss)
      2'b10: q = b >> sh;
      2'b11: q = $unsigned($signed(b) >>> sh);
      default: q = b << sh;
    endcase
    if (te) return {31'h0, ref_lt(a, b, un)};
    if (ae) return s;
    if (le) return g;
    if (se) return q;
    return s;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // drive at falling edge, sample after the rising edge
  task automatic apply(string tag);
    logic [31:0] er;
    logic [2:0]  ef;
    er = ref_res();
    ef = {a[31], a == b, ref_lt(a, b, un)};
    @(posedge clk); #1;
    chk({tag, " result reg"}, r_res, er);
    chk({tag, " result comb"}, c_res, er);
    chk({tag, " R6 flags reg"}, {29'h0, r_ltz, r_eq, r_lt}, {29'h0, ef});
    chk({tag, " R6 flags comb"}, {29'h0, c_ltz, c_eq, c_lt}, {29'h0, ef});
  endtask

  task automatic clr_ctl();
    o2 = 0; ls = 0; ss = 0; li = 0; ae = 0; le = 0; se = 0; te = 0; un = 0; az = 0; sh = 0;
  endtask

  logic [31:0] edges [5] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};

  task automatic t_reset();
    #1;
    chk("R9 reset result", r_res, 32'h0);
    chk("R9 reset flags", {29'h0, r_ltz, r_eq, r_lt}, 32'h0);
  endtask

  task automatic t_precond();
    for (int m = 0; m < 4; m++) begin
      @(negedge clk); clr_ctl(); ae = 1; o2 = 2'(m);
      a = 32'h1234_5678; b = 32'h0F0F_A5A5;
      apply("R1 precond");
    end
  endtask

  task automatic t_sub_edges();
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++) begin
        @(negedge clk); clr_ctl(); ae = 1; o2 = 2'b01; a = edges[i]; b = edges[j];
        apply("R2 sub");
        @(negedge clk); o2 = 2'b00;
        apply("R2 add");
      end
  endtask

  task automatic t_logic();
    for (int f = 0; f < 8; f++) begin
      @(negedge clk); clr_ctl(); le = 1; ls = 2'(f); li = f[2];
      a = 32'hF0F0_3C3C; b = 32'hFF00_5AA5;
      apply("R3 logic");
    end
  endtask

  task automatic t_shift();
    int amts [4] = '{0, 1, 16, 31};
    for (int k = 0; k < 4; k++)
      for (int n = 0; n < 4; n++) begin
        @(negedge clk); clr_ctl(); se = 1; ss = 2'(k); sh = 5'(amts[n]);
        b = 32'h8642_1357;
        apply("R4 shift");
      end
  endtask

  task automatic t_slt();
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        for (int u = 0; u < 2; u++) begin
          @(negedge clk); clr_ctl(); te = 1; un = u[0]; a = edges[i]; b = edges[j];
          apply("R5 slt");
        end
  endtask

  task automatic t_priority();
    @(negedge clk); clr_ctl(); te = 1; ae = 1; le = 1; se = 1; ls = 2'b01;
    a = 32'h8000_0000; b = 32'h1; apply("R7 slt wins");
    @(negedge clk); te = 0; apply("R7 arith wins");
    @(negedge clk); ae = 0; apply("R7 logic wins");
    @(negedge clk); le = 0; sh = 5'd4; apply("R7 shift only");
    @(negedge clk); se = 0; o2 = 2'b01; apply("R7 none adder");
  endtask

  task automatic t_lui();
    @(negedge clk); clr_ctl(); ae = 1; az = 1; o2 = 2'b10;
    a = 32'hDEAD_BEEF; b = 32'h0000_ABCD; apply("R8 lui");
    chk("R8 lui value", c_res, 32'hABCD_0000);
    chk("R8 flags from a", {31'h0, c_ltz}, 32'h1);
  endtask

  task automatic t_latency();
    @(negedge clk); clr_ctl(); ae = 1; a = 32'd5; b = 32'd7; apply("R9 prime");
    @(negedge clk); a = 32'd100; #1;
    chk("R9 comb immediate", c_res, 32'd107);
    chk("R9 reg holds", r_res, 32'd12);
    @(posedge clk); #1;
    chk("R9 reg after edge", r_res, 32'd107);
    @(negedge clk); rst_n = 0; #1;
    chk("R9 async clear", {r_res[31:1], r_ltz | r_eq | r_lt | r_res[0]}, 32'h0);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_random();
    logic [31:0] st = 32'h1ACE_B00C;
    for (int n = 0; n < 400; n++) begin
      @(negedge clk); clr_ctl();
      st ^= st << 13; st ^= st >> 17; st ^= st << 5; a = st;
      st ^= st << 13; st ^= st >> 17; st ^= st << 5; b = st;
      sh = st[4:0]; o2 = st[6:5]; ls = st[8:7]; li = st[9]; ss = st[11:10];
      un = st[12]; az = st[13];
      case (n % 5)
        0: ae = 1; 1: le = 1; 2: se = 1; 3: te = 1; default: ;
      endcase
      if (n % 7 == 0) b = a;
      apply("R7 random");
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_precond();
    t_sub_edges();
    t_logic();
    t_shift();
    t_slt();
    t_priority();
    t_lui();
    t_latency();
    t_random();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule